// File: doc/BRIEF.md
# Shared-Port Serializer Data Sequencer

This block puts a bank of serializer lane buffers behind a single bus word port. Each lane has a mode: idle, transmit or receive. A bus master writes to one port once for each active transmit lane on every transmit-ready event. The block sends each write to the next lane that still waits for data, lowest index first, and skips idle lanes and receive lanes. Reads from the same port work the same way for the receive lanes. They return the captured word of each active receive lane that has not yet been read, lowest index first.

A single slot strobe marks the boundary between time slots and stands in for the serial shifter. At each strobe, the block does the following:
- It copies the transmit buffers onto the lane outputs.
- It captures the incoming lane words into the receive buffers.
- It pulses the two ready events and restarts both sequences at the lowest active lane.
- It raises a sticky underrun flag when any transmit lane went without a write during the slot that just ended.
- It raises a sticky overrun flag when any receive lane was left unread.

Two path-select bits can take each direction off the shared port. A hold input freezes the sequencer and allows the lane modes to be changed. Port accesses that fall in the same cycle as the strobe are ignored.

Top module: `lane_port_seq`

## Requirements
- R1: Each lane has a 2-bit mode (2'b00 idle, 2'b01 transmit, 2'b10 receive, 2'b11 idle). A mode write through `cfg_we`/`cfg_lane`/`cfg_mode` takes effect only while `seq_hold` is 1. A mode write made while `seq_hold` is 0 is ignored.
- R2: Within a slot, successive accepted port writes land in the active transmit lanes in ascending index order, skipping every other lane. At the next strobe, each transmit lane's buffer appears on `lane_tx_data[i*DW +: DW]`.
- R3: Within a slot, successive port reads return the words captured at the last strobe from the active receive lanes in ascending index order. `port_rdata` shows the word of the next lane during the cycle in which `port_rd` is high, and the read consumes that lane at the clock edge.
- R4: `underrun` becomes 1 after a strobe if any active transmit lane got no write since the previous strobe. The first strobe after the hold is released never sets it.
- R5: `overrun` becomes 1 after a strobe if any active receive lane was not read since the previous strobe.
- R6: A write made when every active transmit lane has already been served in the slot is dropped and sets `excess_wr`. A read made when every active receive lane has been read returns 0.
- R7: When `tx_path_sel` is 1, port writes are ignored. When `rx_path_sel` is 1, port reads do not advance the receive sequence.
- R8: `underrun`, `overrun` and `excess_wr` are sticky. Writing 1 to `sts_clr[0]`, `sts_clr[1]` or `sts_clr[2]` clears underrun, overrun or excess respectively. A new event in the same cycle wins over the clear.
- R9: `tx_ready` and `rx_ready` pulse for one cycle right after each strobe taken outside hold. From that point, both sequences restart at their lowest active lane.
- R10: Lanes that are not in transmit mode drive 0 on `lane_tx_data`. While `seq_hold` is 1, all lane outputs are 0, strobes are ignored and no ready event is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seq_hold | input | 1 | Holds the sequencer in reset and enables mode writes |
| cfg_we | input | 1 | Mode write strobe |
| cfg_lane | input | IW | Lane index for the mode write |
| cfg_mode | input | 2 | Mode value to write |
| tx_path_sel | input | 1 | 1 takes transmit off the shared port |
| rx_path_sel | input | 1 | 1 takes receive off the shared port |
| port_wr | input | 1 | Shared-port write |
| port_wdata | input | DW | Shared-port write data |
| port_rd | input | 1 | Shared-port read |
| port_rdata | output | DW | Shared-port read data (next receive lane, or 0) |
| slot_strobe | input | 1 | Time-slot boundary |
| lane_rx_data | input | N*DW | Incoming word of every lane |
| lane_tx_data | output | N*DW | Outgoing word of every lane |
| tx_ready | output | 1 | Transmit-ready event pulse |
| rx_ready | output | 1 | Receive-ready event pulse |
| underrun | output | 1 | Sticky transmit underrun flag |
| overrun | output | 1 | Sticky receive overrun flag |
| excess_wr | output | 1 | Sticky excess-write flag |
| sts_clr | input | 3 | Write-1-to-clear for the three flags |

## Verification
Cycle-level properties run on every cycle:
- Pending transmit and receive lanes are always a subset of the lanes in the matching mode.
- Each read consumes exactly one receive lane.
- Lane modes do not move outside hold.
- The ready events follow each strobe.
- The flags stay set until cleared.

The ascending order of delivery with gaps, the words that reach each lane, the zero returned by excess reads, and the underrun and overrun decisions can only be shown by the bench. It drives mode patterns and access counts, some directed and some random, and compares the results against its own model of each slot.

// File: rtl/lps_pkg.sv
package lps_pkg;
    typedef enum logic [1:0] {
        LM_IDLE = 2'b00,
        LM_TX   = 2'b01,
        LM_RX   = 2'b10,
        LM_RSV  = 2'b11
    } lane_mode_e;
endpackage

// File: rtl/lps_mode_bank.sv
module lps_mode_bank #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          we,
    input  logic [IW-1:0] lane,
    input  logic [1:0]    mode,
    output logic [N-1:0]  act_tx,
    output logic [N-1:0]  act_rx
);
    import lps_pkg::*;

    typedef struct packed {
        logic [N-1:0][1:0] mode;
    } mb_st_t;

    mb_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hold && we && (int'(lane) < N)) begin
            st_d.mode[lane] = mode;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_act
        assign act_tx[i] = (st_q.mode[i] == LM_TX);
        assign act_rx[i] = (st_q.mode[i] == LM_RX);
    end

    // R1
    mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |=> $stable(st_q.mode));
endmodule

// File: rtl/lps_lowbit.sv
module lps_lowbit #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
    assign any = |vec;
endmodule

// File: rtl/lps_tx_path.sv
module lps_tx_path #(
    parameter int N  = 16,
    parameter int DW = 32,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          strobe,
    input  logic [N-1:0]  act,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [N*DW-1:0] lane_out,
    output logic          ready,
    output logic          urun_evt,
    output logic          xs_evt
);
    typedef struct packed {
        logic [N-1:0]          pend;
        logic [N-1:0][DW-1:0]  bufs;
        logic [N-1:0][DW-1:0]  outs;
        logic                  ready;
    } tx_st_t;

    tx_st_t st_d, st_q;
    logic [IW-1:0] tgt;
    logic          have;

    lps_lowbit #(.N(N), .IW(IW)) u_pick (
        .vec (st_q.pend),
        .idx (tgt),
        .any (have)
    );

    always_comb begin
        st_d       = st_q;
        st_d.ready = 1'b0;
        urun_evt   = 1'b0;
        xs_evt     = 1'b0;
        if (hold) begin
            st_d.pend = '0;
            st_d.outs = '0;
        end else if (strobe) begin
            urun_evt = |st_q.pend;
            for (int i = 0; i < N; i++) begin
                st_d.outs[i] = act[i] ? st_q.bufs[i] : '0;
            end
            st_d.pend  = act;
            st_d.ready = 1'b1;
        end else if (wr_en) begin
            if (have) begin
                st_d.bufs[tgt] = wdata;
                st_d.pend[tgt] = 1'b0;
            end else begin
                xs_evt = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lane_out = st_q.outs;
    assign ready    = st_q.ready;

    // R2
    tx_pend_subset_chk: assert property (@(posedge clk) disable iff (!rst_n || hold)
        (st_q.pend & ~act) == '0);
    // R9
    tx_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !hold) |=> ready);
    // R10
    tx_hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (lane_out == '0 && !ready));
    // R2
    tx_one_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && have && !strobe && !hold) |=>
            $countones(st_q.pend) == $countones($past(st_q.pend)) - 1);
endmodule

// File: rtl/lps_rx_path.sv
module lps_rx_path #(
    parameter int N  = 16,
    parameter int DW = 32,
    parameter int IW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold,
    input  logic            strobe,
    input  logic [N-1:0]    act,
    input  logic            rd_en,
    input  logic [N*DW-1:0] lane_in,
    output logic [DW-1:0]   rdata,
    output logic            ready,
    output logic            orun_evt
);
    typedef struct packed {
        logic [N-1:0]          unread;
        logic [N-1:0][DW-1:0]  bufs;
        logic                  ready;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic [IW-1:0] tgt;
    logic          have;

    lps_lowbit #(.N(N), .IW(IW)) u_pick (
        .vec (st_q.unread),
        .idx (tgt),
        .any (have)
    );

    always_comb begin
        st_d       = st_q;
        st_d.ready = 1'b0;
        orun_evt   = 1'b0;
        if (hold) begin
            st_d.unread = '0;
        end else if (strobe) begin
            orun_evt = |st_q.unread;
            for (int i = 0; i < N; i++) begin
                if (act[i]) st_d.bufs[i] = lane_in[i*DW +: DW];
            end
            st_d.unread = act;
            st_d.ready  = 1'b1;
        end else if (rd_en && have) begin
            st_d.unread[tgt] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = have ? st_q.bufs[tgt] : '0;
    assign ready = st_q.ready;

    // R3
    rx_one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && have && !strobe && !hold) |=>
            $countones(st_q.unread) == $countones($past(st_q.unread)) - 1);
    // R5
    rx_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !hold) |=> (st_q.unread == $past(act) && ready));
endmodule

// File: rtl/lane_port_seq.sv
module lane_port_seq #(
    parameter int N  = 16,
    parameter int DW = 32,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            seq_hold,
    input  logic            cfg_we,
    input  logic [IW-1:0]   cfg_lane,
    input  logic [1:0]      cfg_mode,
    input  logic            tx_path_sel,
    input  logic            rx_path_sel,
    input  logic            port_wr,
    input  logic [DW-1:0]   port_wdata,
    input  logic            port_rd,
    output logic [DW-1:0]   port_rdata,
    input  logic            slot_strobe,
    input  logic [N*DW-1:0] lane_rx_data,
    output logic [N*DW-1:0] lane_tx_data,
    output logic            tx_ready,
    output logic            rx_ready,
    output logic            underrun,
    output logic            overrun,
    output logic            excess_wr,
    input  logic [2:0]      sts_clr
);
    typedef struct packed {
        logic xs;
        logic orun;
        logic urun;
    } sts_t;

    sts_t st_d, st_q;

    logic [N-1:0] act_tx, act_rx;
    logic         wr_en, rd_en;
    logic         urun_evt, orun_evt, xs_evt;

    lps_mode_bank #(.N(N), .IW(IW)) u_modes (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (seq_hold),
        .we     (cfg_we),
        .lane   (cfg_lane),
        .mode   (cfg_mode),
        .act_tx (act_tx),
        .act_rx (act_rx)
    );

    assign wr_en = port_wr && !tx_path_sel && !seq_hold && !slot_strobe;
    assign rd_en = port_rd && !rx_path_sel && !seq_hold && !slot_strobe;

    lps_tx_path #(.N(N), .DW(DW), .IW(IW)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (seq_hold),
        .strobe   (slot_strobe),
        .act      (act_tx),
        .wr_en    (wr_en),
        .wdata    (port_wdata),
        .lane_out (lane_tx_data),
        .ready    (tx_ready),
        .urun_evt (urun_evt),
        .xs_evt   (xs_evt)
    );

    lps_rx_path #(.N(N), .DW(DW), .IW(IW)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (seq_hold),
        .strobe   (slot_strobe),
        .act      (act_rx),
        .rd_en    (rd_en),
        .lane_in  (lane_rx_data),
        .rdata    (port_rdata),
        .ready    (rx_ready),
        .orun_evt (orun_evt)
    );

    always_comb begin
        st_d.urun = urun_evt | (st_q.urun & ~sts_clr[0]);
        st_d.orun = orun_evt | (st_q.orun & ~sts_clr[1]);
        st_d.xs   = xs_evt   | (st_q.xs   & ~sts_clr[2]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign underrun  = st_q.urun;
    assign overrun   = st_q.orun;
    assign excess_wr = st_q.xs;

    // R8
    underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !sts_clr[0]) |=> underrun);
    // R8
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !sts_clr[1]) |=> overrun);
    // R7
    tx_path_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_path_sel && !slot_strobe && !excess_wr && sts_clr == 3'b000) |=> !excess_wr);
endmodule

// File: tb/lane_port_seq_tb.sv
module lane_port_seq_tb;
    localparam int N  = 16;
    localparam int DW = 32;
    localparam int IW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic seq_hold = 1'b1, cfg_we = 1'b0;
    logic [IW-1:0] cfg_lane = '0;
    logic [1:0] cfg_mode = '0;
    logic tx_path_sel = 1'b0, rx_path_sel = 1'b0;
    logic port_wr = 1'b0, port_rd = 1'b0, slot_strobe = 1'b0;
    logic [DW-1:0] port_wdata = '0;
    logic [DW-1:0] port_rdata;
    logic [N*DW-1:0] lane_rx_data = '0;
    logic [N*DW-1:0] lane_tx_data;
    logic tx_ready, rx_ready, underrun, overrun, excess_wr;
    logic [2:0] sts_clr = '0;

    always #2 clk = ~clk;

    lane_port_seq #(.N(N), .DW(DW), .IW(IW)) u_dut (
        .clk(clk), .rst_n(rst_n), .seq_hold(seq_hold), .cfg_we(cfg_we),
        .cfg_lane(cfg_lane), .cfg_mode(cfg_mode), .tx_path_sel(tx_path_sel),
        .rx_path_sel(rx_path_sel), .port_wr(port_wr), .port_wdata(port_wdata),
        .port_rd(port_rd), .port_rdata(port_rdata), .slot_strobe(slot_strobe),
        .lane_rx_data(lane_rx_data), .lane_tx_data(lane_tx_data),
        .tx_ready(tx_ready), .rx_ready(rx_ready), .underrun(underrun),
        .overrun(overrun), .excess_wr(excess_wr), .sts_clr(sts_clr)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic [1:0]    m_mode [N];
    logic [DW-1:0] m_tbuf [N];
    logic [DW-1:0] m_rbuf [N];
    logic [DW-1:0] m_out  [N];
    logic [N-1:0]  m_pend, m_unread;
    bit m_ur, m_or, m_xs;

    function automatic logic [N-1:0] mask_of(input logic [1:0] md);
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = (m_mode[i] == md);
        return v;
    endfunction

    function automatic int lowest(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_flags(input string req);
        chk({req, " underrun"}, {31'd0, underrun}, {31'd0, m_ur});
        chk({req, " overrun"},  {31'd0, overrun},  {31'd0, m_or});
        chk({req, " excess"},   {31'd0, excess_wr}, {31'd0, m_xs});
    endtask

    task automatic chk_lanes(input string req);
        for (int i = 0; i < N; i++) chk(req, lane_tx_data[i*DW +: DW], m_out[i]);
    endtask

    task automatic set_mode(input int lane, input logic [1:0] md);
        cfg_we = 1'b1; cfg_lane = IW'(lane); cfg_mode = md;
        @(negedge clk);
        cfg_we = 1'b0;
        if (seq_hold) m_mode[lane] = md;
    endtask

    task automatic set_hold(input bit h);
        seq_hold = h;
        @(negedge clk);
        if (h) begin
            m_pend = '0; m_unread = '0;
            for (int i = 0; i < N; i++) m_out[i] = '0;
        end
    endtask

    task automatic wr(input logic [DW-1:0] d);
        int t;
        port_wr = 1'b1; port_wdata = d;
        @(negedge clk);
        port_wr = 1'b0;
        if (!tx_path_sel && !seq_hold) begin
            t = lowest(m_pend);
            if (t < 0) m_xs = 1;
            else begin m_tbuf[t] = d; m_pend[t] = 1'b0; end
        end
    endtask

    task automatic rd(input string req);
        int t;
        port_rd = 1'b1;
        #1;
        t = lowest(m_unread);
        chk(req, port_rdata, (t < 0) ? '0 : m_rbuf[t]);
        @(negedge clk);
        port_rd = 1'b0;
        if (!rx_path_sel && !seq_hold && t >= 0) m_unread[t] = 1'b0;
    endtask

    task automatic strobe(input string req);
        logic [N-1:0] atx, arx;
        for (int i = 0; i < N; i++) lane_rx_data[i*DW +: DW] = $urandom;
        slot_strobe = 1'b1;
        @(negedge clk);
        slot_strobe = 1'b0;
        atx = mask_of(2'b01); arx = mask_of(2'b10);
        if (!seq_hold) begin
            if (m_pend != 0) m_ur = 1;
            if (m_unread != 0) m_or = 1;
            for (int i = 0; i < N; i++) begin
                m_out[i] = atx[i] ? m_tbuf[i] : '0;
                if (arx[i]) m_rbuf[i] = lane_rx_data[i*DW +: DW];
            end
            m_pend = atx; m_unread = arx;
        end
        chk({req, " R9 tx_ready"}, {31'd0, tx_ready}, {31'd0, !seq_hold});
        chk({req, " R9 rx_ready"}, {31'd0, rx_ready}, {31'd0, !seq_hold});
        chk_lanes({req, " R2/R10 lanes"});
        chk_flags({req, " R4/R5"});
        @(negedge clk);
        chk({req, " R9 pulse end"}, {31'd0, tx_ready | rx_ready}, 32'd0);
    endtask

    task automatic clr(input logic [2:0] m);
        sts_clr = m;
        @(negedge clk);
        sts_clr = '0;
        if (m[0]) m_ur = 0;
        if (m[1]) m_or = 0;
        if (m[2]) m_xs = 0;
    endtask

    task automatic fill_tx();
        int k = $countones(mask_of(2'b01));
        for (int j = 0; j < k; j++) wr($urandom);
    endtask

    task automatic drain_rx(input string req);
        int k = $countones(mask_of(2'b10));
        for (int j = 0; j < k; j++) rd(req);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < N; i++) begin
            m_mode[i] = 2'b00; m_tbuf[i] = '0; m_rbuf[i] = '0; m_out[i] = '0;
        end
        m_pend = '0; m_unread = '0; m_ur = 0; m_or = 0; m_xs = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state R10 R8
        chk_lanes("R10 reset lanes");
        chk_flags("R8 reset flags");
        chk("R3 reset rdata", port_rdata, '0);

        // strobe during hold ignored R10
        strobe("R10 hold strobe");

        // directed: tx 0,4,5,7 ; rx 1,2,3,6
        set_mode(0, 2'b01); set_mode(4, 2'b01); set_mode(5, 2'b01); set_mode(7, 2'b01);
        set_mode(1, 2'b10); set_mode(2, 2'b10); set_mode(3, 2'b10); set_mode(6, 2'b10);
        set_mode(9, 2'b11);
        set_hold(0);
        strobe("R4 first slot");
        wr(32'hA000_0000); wr(32'hA000_0004); wr(32'hA000_0005); wr(32'hA000_0007);
        drain_rx("R3 ordered read");
        strobe("R2 ordered write");
        chk("R2 lane4", lane_tx_data[4*DW +: DW], 32'hA000_0004);
        chk("R2 lane7", lane_tx_data[7*DW +: DW], 32'hA000_0007);

        // excess write and read R6
        fill_tx(); drain_rx("R3 drain");
        wr(32'hDEAD_BEEF);
        rd("R6 excess read zero");
        chk_flags("R6 excess flag");
        // clear with simultaneous event: set wins R8
        sts_clr = 3'b100; port_wr = 1'b1; port_wdata = 32'h1;
        @(negedge clk);
        sts_clr = '0; port_wr = 1'b0;
        chk_flags("R8 set beats clear");
        clr(3'b100);
        chk_flags("R8 clear");
        strobe("R6 slot after excess");

        // underrun R4
        wr(32'h1111_0000); wr(32'h1111_0004);
        drain_rx("R3 drain2");
        strobe("R4 underrun");
        fill_tx(); drain_rx("R3 drain3");
        strobe("R8 underrun sticky");
        clr(3'b001);
        chk_flags("R8 underrun cleared");

        // overrun R5
        fill_tx(); rd("R5 partial read");
        strobe("R5 overrun");
        clr(3'b010);
        chk_flags("R8 overrun cleared");

        // path select R7
        fill_tx(); drain_rx("R3 drain4");
        strobe("R7 prep");
        tx_path_sel = 1'b1; rx_path_sel = 1'b1;
        wr(32'h7777_7777); wr(32'h7777_7778);
        rd("R7 read no advance"); rd("R7 read same lane");
        chk_flags("R7 no excess");
        tx_path_sel = 1'b0; rx_path_sel = 1'b0;
        fill_tx(); drain_rx("R7 drain after");
        strobe("R7 lanes after reenable");

        // mode write outside hold ignored R1
        set_mode(9, 2'b01);
        fill_tx(); wr(32'h9999_9999);
        chk_flags("R1 mode change ignored");
        clr(3'b111);
        drain_rx("R1 drain");
        strobe("R1 lane9 silent");

        // random rounds
        for (int r = 0; r < 40; r++) begin
            int ntx, nrx;
            set_hold(1);
            chk_lanes("R10 hold lanes");
            for (int i = 0; i < N; i++) set_mode(i, 2'($urandom_range(0, 3)));
            set_hold(0);
            strobe("R9 rand first");
            ntx = $countones(mask_of(2'b01)) + $urandom_range(0, 2) - 1;
            nrx = $countones(mask_of(2'b10)) + $urandom_range(0, 2) - 1;
            for (int j = 0; j < ntx; j++) wr($urandom);
            for (int j = 0; j < nrx; j++) rd("R3 rand read");
            chk_flags("R6 rand flags");
            strobe("R2 rand slot");
            fill_tx(); drain_rx("R3 rand drain");
            strobe("R2 rand slot2");
            clr(3'($urandom_range(0, 7)));
            chk_flags("R8 rand clear");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule